// File: doc/BRIEF.md
# Oversize Receive Frame Counter

This block keeps a receive statistic for an Ethernet MAC: the number of frames whose measured length is larger than a programmable maximum. At the end of every received frame the MAC presents a one-cycle strobe, the measured length and a flag saying whether the frame ended on a partial octet. A frame is counted only if it is longer than the limit and octet-aligned. Frames with a partial octet are left out of this count and announced on a separate pulse output, which feeds a residual-bit counter elsewhere.

Software reaches the block over a simple register bus with two word registers. Address 0 holds the count and address 1 holds the maximum length. The count never wraps. A mode input picks how software clears it: either every read of the count clears it, or a write of a fixed key value clears it.

Top module: `rx_oversize_counter`

## Requirements
- R1: After reset the count register (address 0) reads 0 and the maximum-length register (address 1) reads 1518. The count occupies bits 15:0 of the word at address 0.
- R2: On a frame-end strobe without the residual flag, the count increments by one only when the frame length is strictly greater than the maximum length. A length equal to or below the limit leaves the count unchanged.
- R3: Once the count is 0xFFFF, further qualifying frames leave it at 0xFFFF until it is cleared.
- R4: A frame-end strobe with the residual flag set never changes the count, whatever its length. The cycle after such a strobe, the residual pulse output is 1. It is 0 in every other cycle.
- R5: With the clear mode input at 1, a read of address 0 returns the count as it stood before the read, and the count is 0 from the next cycle on. In this mode, writes to address 0 have no effect.
- R6: With the clear mode input at 0, the count is cleared only by a write of 0x11111111 to address 0. A write of any other value and any read leave it unchanged.
- R7: Bits 31:16 of read data are always 0 at both addresses, whatever was written.
- R8: If a clear (by read or by key write) falls in the same cycle as a qualifying frame end, the count becomes 1.
- R9: A write to address 1 loads bits 15:0 of the write data into the maximum length. Later frames are compared against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end_i | input | 1 | One-cycle strobe at the end of a received frame |
| frame_len_i | input | 16 | Measured frame length in bytes, valid with the strobe |
| frame_resid_i | input | 1 | Frame ended with a partial octet, valid with the strobe |
| clr_on_read_i | input | 1 | 1: a read of the count clears it; 0: a key write clears it |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 count, 1 maximum length |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the selected register |
| resid_pulse_o | output | 1 | One-cycle pulse for each frame ending with a partial octet |

## Verification
Two events can land in the same cycle: a software clear of the count and a qualifying frame end. The bench drives a frame strobe in the very cycle of a clearing read in read-clear mode. It does the same in the cycle of a key write in write-clear mode. Each time it then reads the count back and expects 1, so the frame is neither lost nor counted twice. For the read case it also expects the read data to show the count from before the clear.

// File: rtl/rx_ovs_pkg.sv
package rx_ovs_pkg;
    localparam int unsigned CNT_W   = 16;
    localparam int unsigned LEN_W   = 16;
    localparam int unsigned DATA_W  = 32;

    typedef enum logic {
        REG_COUNT  = 1'b0,
        REG_MAXLEN = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] max_len;
        logic             resid;
    } ovs_state_t;
endpackage

// File: rtl/rx_ovs_qualify.sv
module rx_ovs_qualify #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             frame_end_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic             frame_resid_i,
    input  logic [LEN_W-1:0] max_len_i,
    output logic             count_evt_o,
    output logic             resid_evt_o
);
    always_comb begin
        count_evt_o = frame_end_i && !frame_resid_i && (frame_len_i > max_len_i);
        resid_evt_o = frame_end_i && frame_resid_i;
    end
endmodule

// File: rtl/rx_ovs_clear.sv
module rx_ovs_clear
    import rx_ovs_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter logic [DATA_W-1:0] CLR_KEY = 32'h1111_1111
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              clr_on_read_i,
    output logic              clr_o,
    output logic              max_wr_o
);
    logic hit_cnt;
    always_comb begin
        hit_cnt  = (addr_i == REG_COUNT);
        max_wr_o = wr_i && (addr_i == REG_MAXLEN);
        if (clr_on_read_i) clr_o = rd_i && hit_cnt;
        else               clr_o = wr_i && hit_cnt && (wdata_i == CLR_KEY);
    end
endmodule

// File: rtl/rx_ovs_count_next.sv
module rx_ovs_count_next #(
    parameter int unsigned CNT_W    = 16,
    parameter bit          SATURATE = 1'b1
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_top;
    generate
        if (SATURATE) begin : g_sat
            assign at_top = (cnt_i == CNT_MAX);
        end else begin : g_wrap
            assign at_top = 1'b0;
        end
    endgenerate

    always_comb begin
        if (clr_i)                cnt_o = inc_i ? CNT_ONE : '0;
        else if (inc_i && !at_top) cnt_o = cnt_i + CNT_ONE;
        else                      cnt_o = cnt_i;
    end
endmodule

// File: rtl/rx_oversize_counter.sv
module rx_oversize_counter
    import rx_ovs_pkg::*;
#(
    parameter int unsigned       CNT_W      = rx_ovs_pkg::CNT_W,
    parameter int unsigned       LEN_W      = rx_ovs_pkg::LEN_W,
    parameter int unsigned       DATA_W     = rx_ovs_pkg::DATA_W,
    parameter logic [LEN_W-1:0]  MAXLEN_RST = 16'd1518,
    parameter logic [DATA_W-1:0] CLR_KEY    = 32'h1111_1111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic [15:0]       frame_len_i,
    input  logic              frame_resid_i,
    input  logic              clr_on_read_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic              bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              resid_pulse_o
);
    localparam int unsigned CNT_PAD = DATA_W - CNT_W;
    localparam int unsigned LEN_PAD = DATA_W - LEN_W;

    ovs_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic count_evt, resid_evt, clr, max_wr;

    assign cnt_q = st_q.cnt;

    rx_ovs_qualify #(.LEN_W(LEN_W)) u_qual (
        .frame_end_i   (frame_end_i),
        .frame_len_i   (frame_len_i),
        .frame_resid_i (frame_resid_i),
        .max_len_i     (st_q.max_len),
        .count_evt_o   (count_evt),
        .resid_evt_o   (resid_evt)
    );

    rx_ovs_clear #(.DATA_W(DATA_W), .CLR_KEY(CLR_KEY)) u_clr (
        .rd_i          (bus_rd_i),
        .wr_i          (bus_wr_i),
        .addr_i        (bus_addr_i),
        .wdata_i       (bus_wdata_i),
        .clr_on_read_i (clr_on_read_i),
        .clr_o         (clr),
        .max_wr_o      (max_wr)
    );

    rx_ovs_count_next #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_next (
        .cnt_i (st_q.cnt),
        .clr_i (clr),
        .inc_i (count_evt),
        .cnt_o (cnt_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = cnt_nx;
        st_d.resid   = resid_evt;
        if (max_wr) st_d.max_len = bus_wdata_i[LEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.max_len <= MAXLEN_RST;
            st_q.resid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr_i == REG_MAXLEN) bus_rdata_o = {{LEN_PAD{1'b0}}, st_q.max_len};
        else                          bus_rdata_o = {{CNT_PAD{1'b0}}, st_q.cnt};
    end

    assign resid_pulse_o = st_q.resid;
endmodule

// File: rtl/rx_oversize_counter_chk.sv
module rx_oversize_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_end_i,
    input logic [15:0] frame_len_i,
    input logic        frame_resid_i,
    input logic        clr_on_read_i,
    input logic        bus_rd_i,
    input logic        bus_wr_i,
    input logic        bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        resid_pulse_o,
    input logic [15:0] cnt
);
    logic [15:0] lim_seen;
    logic        lim_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_seen <= 16'd1518;
            lim_ok   <= 1'b0;
        end else begin
            lim_ok <= 1'b1;
            if (bus_wr_i && bus_addr_i) lim_seen <= bus_wdata_i[15:0];
        end
    end

    logic any_clr, good_frame;
    assign any_clr = (clr_on_read_i && bus_rd_i && !bus_addr_i) ||
                     (!clr_on_read_i && bus_wr_i && !bus_addr_i && bus_wdata_i == 32'h1111_1111);
    assign good_frame = lim_ok && frame_end_i && !frame_resid_i && (frame_len_i > lim_seen);

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 16'hFFFF && !any_clr) |=> (cnt == 16'hFFFF)); // R3
    AST_RESID_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && frame_resid_i && !any_clr) |=> $stable(cnt)); // R4
    AST_RESID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && frame_resid_i) |=> resid_pulse_o); // R4
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_read_i && bus_rd_i && !bus_addr_i && !frame_end_i) |=> (cnt == 16'd0)); // R5
    AST_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_on_read_i && !frame_end_i && !any_clr) |=> $stable(cnt)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[31:16] == 16'd0); // R7
    AST_CLR_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && good_frame) |=> (cnt == 16'd1)); // R8
endmodule

bind rx_oversize_counter rx_oversize_counter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_end_i   (frame_end_i),
    .frame_len_i   (frame_len_i),
    .frame_resid_i (frame_resid_i),
    .clr_on_read_i (clr_on_read_i),
    .bus_rd_i      (bus_rd_i),
    .bus_wr_i      (bus_wr_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .resid_pulse_o (resid_pulse_o),
    .cnt           (cnt_q)
);

// File: tb/rx_oversize_counter_tb.sv
`timescale 1ns/1ps
module rx_oversize_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0;
    logic [15:0] frame_len = '0;
    logic        frame_res = 1'b0;
    logic        mode = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        resid;

    always #4 clk = ~clk;

    rx_oversize_counter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end), .frame_len_i(frame_len),
        .frame_resid_i(frame_res), .clr_on_read_i(mode), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .resid_pulse_o(resid)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic exp_resid = 1'b0;

    // monitor: read data pops the scoreboard, residual pulse checked every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd) begin
                item_t it;
                n_cmp++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: read with no expectation, act=%h exp=none", rdata);
                end else begin
                    it = sb_q.pop_front();
                    if (rdata !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: act=%h exp=%h", it.tag, rdata, it.exp);
                    end
                end
            end
            n_cmp++;
            if (resid !== exp_resid) begin
                n_bad++;
                $display("FAIL R4 pulse: act=%b exp=%b", resid, exp_resid);
            end
        end
    end

    always @(posedge clk) exp_resid <= rst_n && frame_end && frame_res;

    task automatic cyc(input logic fe, input logic [15:0] len, input logic res,
                       input logic r, input logic w, input logic a, input logic [31:0] wd,
                       input logic [31:0] exp, input string tag);
        frame_end = fe; frame_len = len; frame_res = res;
        rd = r; wr = w; addr = a; wdata = wd;
        if (r) begin
            item_t it;
            it.exp = exp; it.tag = tag;
            sb_q.push_back(it);
        end
        @(posedge clk); #1;
        frame_end = 0; frame_res = 0; rd = 0; wr = 0; addr = 0; wdata = '0;
    endtask

    task automatic frame(input logic [15:0] len, input logic res);
        cyc(1, len, res, 0, 0, 0, '0, '0, "");
    endtask
    task automatic rd_chk(input logic a, input logic [31:0] exp, input string tag);
        cyc(0, '0, 0, 1, 0, a, '0, exp, tag);
    endtask
    task automatic wr_reg(input logic a, input logic [31:0] wd);
        cyc(0, '0, 0, 0, 1, a, wd, '0, "");
    endtask

    bit done = 0;
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_chk(0, 32'd0, "R1 count reset");
        rd_chk(1, 32'd1518, "R1 limit reset");

        frame(16'd1518, 0);
        frame(16'd1519, 0);
        frame(16'd2000, 0);
        frame(16'd64, 0);
        rd_chk(0, 32'd2, "R2 strict greater");
        rd_chk(0, 32'd2, "R6 read keeps count");

        frame(16'd3000, 1);
        rd_chk(0, 32'd2, "R4 residual skipped");

        wr_reg(0, 32'h1234_5678);
        rd_chk(0, 32'd2, "R6 wrong key ignored");
        wr_reg(0, 32'h1111_1111);
        rd_chk(0, 32'd0, "R6 key clears");

        wr_reg(1, 32'hABCD_0064);
        rd_chk(1, 32'h0000_0064, "R9 R7 limit write");
        frame(16'd101, 0);
        frame(16'd100, 0);
        rd_chk(0, 32'd1, "R9 new limit used");

        mode = 1'b1;
        wr_reg(0, 32'h1111_1111);
        rd_chk(0, 32'd1, "R5 pre-clear value");
        rd_chk(0, 32'd0, "R5 cleared");
        frame(16'd2000, 0);
        frame(16'd2000, 0);
        cyc(1, 16'd2000, 0, 1, 0, 0, '0, 32'd2, "R8 read with frame old value");
        rd_chk(0, 32'd1, "R8 read clear plus frame");
        rd_chk(1, 32'h64, "R5 limit read no clear");
        rd_chk(0, 32'd0, "R5 cleared again");

        mode = 1'b0;
        frame(16'd500, 0);
        frame(16'd500, 0);
        cyc(1, 16'd500, 0, 0, 1, 0, 32'h1111_1111, '0, "");
        rd_chk(0, 32'd1, "R8 key clear plus frame");

        wr_reg(0, 32'h1111_1111);
        for (int i = 0; i < 65540; i++) frame(16'd900, 0);
        rd_chk(0, 32'h0000_FFFF, "R3 saturated");
        frame(16'd900, 0);
        frame(16'd900, 1);
        rd_chk(0, 32'h0000_FFFF, "R3 R7 still saturated");
        wr_reg(0, 32'h1111_1111);
        rd_chk(0, 32'd0, "R3 cleared after saturation");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: act=%0d pending exp=0", sb_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule